// File: doc/BRIEF.md
# Sector Address Validator and Sequencer

This block sits in front of each sector transfer in a disk controller. When a transfer starts, it loads the starting sector and head and the command kind. On each check request it tests the current position against the attached drive's geometry. If the position is valid, it returns the linear sector index; if not, it returns error flags. After a check that passes, it advances the sector and carries into the head. A multi-sector transfer therefore needs only one request per sector.

A first-sector flag decides how an out-of-range head is reported. On the first sector it is an address-compare failure, and the drive is marked unsafe. On any later sector it is a cylinder overflow. A small combinational fill stage completes a sector buffer that arrived short. Writes are padded with the last byte received and reads with zeros. The drive's current cylinder, its geometry, and its presence and write-protect state are live inputs from the drive logic.

Top module: `sector_seq`

## Requirements
- R1: After reset, `rsp_valid_o`, `err_o`, `lba_o`, `set_seek_inc_o` and `set_unsafe_o` are 0. `sec_o` and `head_o` are 0 and `first_o` is 0.
- R2: `start_i` loads the sector from the low 6 bits of `sec_i`, loads `head_i` and the command `cmd_i`, and sets `first_o`. The command encoding is 0 read, 1 write, 2 read-check and 3 format. A `req_i` in the same cycle as `start_i` is ignored and gives no response.
- R3: A `req_i` without `start_i` gives exactly one cycle of `rsp_valid_o` on the next cycle. That cycle carries the registered result. In cycles without a response, `err_o`, `lba_o` and both flag pulses are 0.
- R4: With `present_i` low, the response sets `err_o` bit 0 (transfer error). This check has priority over every other check.
- R5: A write command (1) to a drive with `wprot_i` high sets `err_o` bit 1 (write protect). Other commands do not see this check.
- R6: A cylinder `cyl_i` at or above `cylinders_i` sets `err_o` bit 0 and pulses `set_seek_inc_o` with the response.
- R7: A head at or above `surfaces_i` on the first sector sets `err_o` bit 2 (address compare) and pulses `set_unsafe_o`. On a later sector it sets `err_o` bit 3 (cylinder overflow) with no unsafe pulse. At most one of bits 0, 2 and 3 is ever set.
- R8: A passing check returns `lba_o` = ((cylinder × surfaces + head) × 64) + sector.
- R9: A passing check increments the sector modulo 64. When the sector wraps to 0, the head increments. The check also clears `first_o`.
- R10: A failing check leaves the sector, head and `first_o` unchanged and returns `lba_o` = 0.
- R11: Read-check (2) behaves like a read. Format (3) runs the same checks and adds `err_o` bit 1 to every response. A format check that passes still returns the address and advances.
- R12: The fill stage behaves as follows. `pad_byte_o` equals `pad_data_i` when `pad_idx_i` < `pad_cnt_i`. Otherwise it equals `pad_last_i` when `pad_wr_i` is high, and 0 when `pad_wr_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer: load position and command |
| cmd_i | input | 2 | Command kind: 0 read, 1 write, 2 read-check, 3 format |
| sec_i | input | 8 | Starting sector byte; low 6 bits are used |
| head_i | input | 5 | Starting head |
| cyl_i | input | 12 | Drive's current cylinder |
| present_i | input | 1 | Drive attached |
| wprot_i | input | 1 | Drive write protected |
| surfaces_i | input | 5 | Surface count of the drive |
| cylinders_i | input | 12 | Cylinder count of the drive |
| req_i | input | 1 | Check request for the next sector |
| rsp_valid_o | output | 1 | Result valid |
| err_o | output | 4 | Error flags: 0 transfer, 1 write protect, 2 address compare, 3 cylinder overflow |
| lba_o | output | 23 | Linear sector index |
| set_seek_inc_o | output | 1 | Pulse: set drive seek-incomplete |
| set_unsafe_o | output | 1 | Pulse: set drive unsafe |
| sec_o | output | 6 | Current sector |
| head_o | output | 5 | Current head |
| first_o | output | 1 | First sector of transfer still pending |
| pad_wr_i | input | 1 | Fill mode: 1 write, 0 read |
| pad_cnt_i | input | 9 | Bytes actually received (0 to 256) |
| pad_idx_i | input | 8 | Byte position within sector |
| pad_data_i | input | 8 | Received byte at that position |
| pad_last_i | input | 8 | Last byte received |
| pad_byte_o | output | 8 | Byte to store at that position |

## Verification
Runs of back-to-back requests cross sector 63. They show that the carry reaches the head and that the addresses stay continuous across the carry. Error patterns are applied one at a time and then in pairs: no drive with write protect, and a bad cylinder together with a bad head. These patterns expose the priority order. The same bad head is tried both on the first sector and after a passing sector, which separates address-compare from cylinder overflow. Format, read-check, and a request colliding with a start are also applied, and fill cases at counts 0, part-way and 256 separate write padding from read padding.

// File: rtl/sector_seq_pkg.sv
`timescale 1ns/1ps
package sector_seq_pkg;
  localparam int ERR_W      = 4;
  localparam int ERR_XFER   = 0;
  localparam int ERR_WPROT  = 1;
  localparam int ERR_ADDR   = 2;
  localparam int ERR_CYLOVF = 3;
  localparam logic [ERR_W-1:0] CAUSE_MASK = 4'b1101;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_RCHECK = 2'd2,
    CMD_FORMAT = 2'd3
  } cmd_e;
endpackage

// File: rtl/sector_geom_check.sv
`timescale 1ns/1ps
module sector_geom_check
  import sector_seq_pkg::*;
#(
  parameter int HEAD_W = 5,
  parameter int CYL_W  = 12
) (
  input  logic              present_i,
  input  logic              wprot_i,
  input  logic              is_write_i,
  input  logic              first_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [CYL_W-1:0]  cylinders_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [HEAD_W-1:0] surfaces_i,
  output logic [ERR_W-1:0]  err_o,
  output logic              pass_o,
  output logic              seek_inc_o,
  output logic              unsafe_o
);
  // priority: presence, protect, cylinder, head
  always_comb begin
    err_o      = '0;
    seek_inc_o = 1'b0;
    unsafe_o   = 1'b0;
    if (!present_i) begin
      err_o[ERR_XFER] = 1'b1;
    end else if (wprot_i && is_write_i) begin
      err_o[ERR_WPROT] = 1'b1;
    end else if (cyl_i >= cylinders_i) begin
      err_o[ERR_XFER] = 1'b1;
      seek_inc_o      = 1'b1;
    end else if (head_i >= surfaces_i) begin
      if (first_i) begin
        err_o[ERR_ADDR] = 1'b1;
        unsafe_o        = 1'b1;
      end else begin
        err_o[ERR_CYLOVF] = 1'b1;
      end
    end
    pass_o = (err_o == '0);
  end
endmodule

// File: rtl/sector_lba_calc.sv
`timescale 1ns/1ps
module sector_lba_calc #(
  parameter int SEC_W  = 6,
  parameter int HEAD_W = 5,
  parameter int CYL_W  = 12,
  localparam int TRK_W = CYL_W + HEAD_W,
  localparam int LBA_W = TRK_W + SEC_W
) (
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [HEAD_W-1:0] surfaces_i,
  input  logic [SEC_W-1:0]  sec_i,
  output logic [LBA_W-1:0]  lba_o
);
  logic [TRK_W-1:0] track;
  // fits TRK_W whenever head < surfaces
  assign track = TRK_W'(cyl_i) * TRK_W'(surfaces_i) + TRK_W'(head_i);
  assign lba_o = {track, sec_i};
endmodule

// File: rtl/sector_pad_fill.sv
`timescale 1ns/1ps
module sector_pad_fill #(
  parameter int BYTES = 256,
  localparam int IDX_W = $clog2(BYTES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic [7:0]       last_i,
  output logic [7:0]       byte_o
);
  logic received;
  assign received = ({1'b0, idx_i} < cnt_i);
  assign byte_o   = received ? data_i : (wr_i ? last_i : 8'h00);
endmodule

// File: rtl/sector_seq.sv
`timescale 1ns/1ps
module sector_seq
  import sector_seq_pkg::*;
#(
  parameter int SEC_IN_W = 8,
  parameter int SEC_W    = 6,
  parameter int HEAD_W   = 5,
  parameter int CYL_W    = 12,
  parameter int BYTES    = 256,
  localparam int LBA_W   = CYL_W + HEAD_W + SEC_W,
  localparam int IDX_W   = $clog2(BYTES),
  localparam int CNT_W   = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          cmd_i,
  input  logic [SEC_IN_W-1:0] sec_i,
  input  logic [HEAD_W-1:0]   head_i,
  input  logic [CYL_W-1:0]    cyl_i,
  input  logic                present_i,
  input  logic                wprot_i,
  input  logic [HEAD_W-1:0]   surfaces_i,
  input  logic [CYL_W-1:0]    cylinders_i,
  input  logic                req_i,
  output logic                rsp_valid_o,
  output logic [ERR_W-1:0]    err_o,
  output logic [LBA_W-1:0]    lba_o,
  output logic                set_seek_inc_o,
  output logic                set_unsafe_o,
  output logic [SEC_W-1:0]    sec_o,
  output logic [HEAD_W-1:0]   head_o,
  output logic                first_o,
  input  logic                pad_wr_i,
  input  logic [CNT_W-1:0]    pad_cnt_i,
  input  logic [IDX_W-1:0]    pad_idx_i,
  input  logic [7:0]          pad_data_i,
  input  logic [7:0]          pad_last_i,
  output logic [7:0]          pad_byte_o
);
  cmd_e              cmd_q;
  logic [SEC_W-1:0]  sec_q;
  logic [HEAD_W-1:0] head_q;
  logic              first_q;
  logic              rsp_q, seek_q, unsafe_q;
  logic [ERR_W-1:0]  err_q;
  logic [LBA_W-1:0]  lba_q;

  logic [ERR_W-1:0]  chk_err, rsp_err;
  logic              chk_pass, chk_seek, chk_unsafe;
  logic [LBA_W-1:0]  chk_lba;
  logic              do_check;

  assign do_check = req_i && !start_i;

  sector_geom_check #(.HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_check (
    .present_i   (present_i),
    .wprot_i     (wprot_i),
    .is_write_i  (cmd_q == CMD_WRITE),
    .first_i     (first_q),
    .cyl_i       (cyl_i),
    .cylinders_i (cylinders_i),
    .head_i      (head_q),
    .surfaces_i  (surfaces_i),
    .err_o       (chk_err),
    .pass_o      (chk_pass),
    .seek_inc_o  (chk_seek),
    .unsafe_o    (chk_unsafe)
  );

  sector_lba_calc #(.SEC_W(SEC_W), .HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_lba (
    .cyl_i      (cyl_i),
    .head_i     (head_q),
    .surfaces_i (surfaces_i),
    .sec_i      (sec_q),
    .lba_o      (chk_lba)
  );

  sector_pad_fill #(.BYTES(BYTES)) u_pad (
    .wr_i   (pad_wr_i),
    .cnt_i  (pad_cnt_i),
    .idx_i  (pad_idx_i),
    .data_i (pad_data_i),
    .last_i (pad_last_i),
    .byte_o (pad_byte_o)
  );

  // format commands always flag write protect on top of the check
  always_comb begin
    rsp_err = chk_err;
    if (cmd_q == CMD_FORMAT) rsp_err[ERR_WPROT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= CMD_READ;
      sec_q    <= '0;
      head_q   <= '0;
      first_q  <= 1'b0;
      rsp_q    <= 1'b0;
      err_q    <= '0;
      lba_q    <= '0;
      seek_q   <= 1'b0;
      unsafe_q <= 1'b0;
    end else begin
      rsp_q    <= do_check;
      err_q    <= do_check ? rsp_err : '0;
      lba_q    <= (do_check && chk_pass) ? chk_lba : '0;
      seek_q   <= do_check && chk_seek;
      unsafe_q <= do_check && chk_unsafe;
      if (start_i) begin
        cmd_q   <= cmd_e'(cmd_i);
        sec_q   <= sec_i[SEC_W-1:0];
        head_q  <= head_i;
        first_q <= 1'b1;
      end else if (req_i && chk_pass) begin
        sec_q   <= sec_q + 1'b1;
        first_q <= 1'b0;
        if (&sec_q) head_q <= head_q + 1'b1;
      end
    end
  end

  assign rsp_valid_o    = rsp_q;
  assign err_o          = err_q;
  assign lba_o          = lba_q;
  assign set_seek_inc_o = seek_q;
  assign set_unsafe_o   = unsafe_q;
  assign sec_o          = sec_q;
  assign head_o         = head_q;
  assign first_o        = first_q;
endmodule

// File: rtl/sector_seq_chk.sv
`timescale 1ns/1ps
module sector_seq_chk
  import sector_seq_pkg::*;
#(
  parameter int SEC_W  = 6,
  parameter int HEAD_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              req_i,
  input logic              rsp_valid_o,
  input logic [ERR_W-1:0]  err_o,
  input logic              set_unsafe_o,
  input logic [SEC_W-1:0]  sec_o,
  input logic [HEAD_W-1:0] head_o,
  input logic              first_o,
  input cmd_e              cmd_q
);
  logic failed;
  assign failed = (cmd_q == CMD_FORMAT) ? |(err_o & CAUSE_MASK) : |err_o;

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !start_i |=> rsp_valid_o);

  // R2
  start_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> first_o && !rsp_valid_o);

  // R10
  err_holds_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && failed |-> $stable(sec_o) && $stable(head_o) && $stable(first_o));

  // R9
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !failed |-> sec_o == SEC_W'($past(sec_o) + 1'b1) && !first_o);

  // R9
  head_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !failed && (&$past(sec_o)) |-> head_o == HEAD_W'($past(head_o) + 1'b1));

  // R7
  unsafe_acf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_unsafe_o |-> rsp_valid_o && err_o[ERR_ADDR]);

  // R7
  one_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(err_o & CAUSE_MASK) <= 1);
endmodule

bind sector_seq sector_seq_chk #(.SEC_W(SEC_W), .HEAD_W(HEAD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .req_i        (req_i),
  .rsp_valid_o  (rsp_valid_o),
  .err_o        (err_o),
  .set_unsafe_o (set_unsafe_o),
  .sec_o        (sec_o),
  .head_o       (head_o),
  .first_o      (first_o),
  .cmd_q        (cmd_q)
);

// File: tb/sector_seq_tb.sv
`timescale 1ns/1ps
module sector_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [7:0]  sec_in = 8'd0;
  logic [4:0]  head_in = 5'd0;
  logic [11:0] cyl = 12'd0;
  logic        present = 1'b1;
  logic        wprot = 1'b0;
  logic [4:0]  surf = 5'd5;
  logic [11:0] cyls = 12'd823;
  logic        req = 1'b0;
  logic        pad_wr = 1'b0;
  logic [8:0]  pad_cnt = 9'd0;
  logic [7:0]  pad_idx = 8'd0;
  logic [7:0]  pad_data = 8'd0;
  logic [7:0]  pad_last = 8'd0;

  logic        rsp_valid, seek_o, unsafe_o, first_o;
  logic [3:0]  err_o;
  logic [22:0] lba_o;
  logic [5:0]  sec_o;
  logic [4:0]  head_o;
  logic [7:0]  pad_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_sec = 0, m_head = 0, m_first = 0, m_cmd = 0;
  int e_rsp = 0, e_err = 0, e_lba = 0, e_seek = 0, e_uns = 0;

  always #2 clk = ~clk;

  sector_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .sec_i(sec_in),
    .head_i(head_in), .cyl_i(cyl), .present_i(present), .wprot_i(wprot),
    .surfaces_i(surf), .cylinders_i(cyls), .req_i(req), .rsp_valid_o(rsp_valid),
    .err_o(err_o), .lba_o(lba_o), .set_seek_inc_o(seek_o), .set_unsafe_o(unsafe_o),
    .sec_o(sec_o), .head_o(head_o), .first_o(first_o), .pad_wr_i(pad_wr),
    .pad_cnt_i(pad_cnt), .pad_idx_i(pad_idx), .pad_data_i(pad_data),
    .pad_last_i(pad_last), .pad_byte_o(pad_byte)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pad_model();
    if (int'(pad_idx) < int'(pad_cnt)) return int'(pad_data);
    return pad_wr ? int'(pad_last) : 0;
  endfunction

  task automatic compare_all();
    chk("R3",  "rsp_valid", int'(rsp_valid), e_rsp);
    chk("R4",  "err",       int'(err_o),     e_err);
    chk("R8",  "lba",       int'(lba_o),     e_lba);
    chk("R6",  "seek_inc",  int'(seek_o),    e_seek);
    chk("R7",  "unsafe",    int'(unsafe_o),  e_uns);
    chk("R9",  "sector",    int'(sec_o),     m_sec);
    chk("R9",  "head",      int'(head_o),    m_head);
    chk("R10", "first",     int'(first_o),   m_first);
    chk("R12", "pad_byte",  int'(pad_byte),  pad_model());
  endtask

  // one clock: reference model evaluated at the edge, outputs compared mid-cycle
  task automatic step();
    bit pass;
    @(posedge clk);
    e_rsp = (req && !start) ? 1 : 0;
    e_err = 0; e_lba = 0; e_seek = 0; e_uns = 0;
    if (start) begin
      m_sec = int'(sec_in) % 64; m_head = int'(head_in); m_first = 1; m_cmd = int'(cmd);
    end else if (req) begin
      pass = 1'b0;
      if (!present) e_err = 1;
      else if (wprot && m_cmd == 1) e_err = 2;
      else if (int'(cyl) >= int'(cyls)) begin e_err = 1; e_seek = 1; end
      else if (m_head >= int'(surf)) begin
        if (m_first != 0) begin e_err = 4; e_uns = 1; end
        else e_err = 8;
      end else pass = 1'b1;
      if (m_cmd == 3) e_err = e_err | 2;
      if (pass) begin
        e_lba = ((int'(cyl) * int'(surf)) + m_head) * 64 + m_sec;
        m_sec = (m_sec + 1) % 64;
        if (m_sec == 0) m_head = (m_head + 1) % 32;
        m_first = 0;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic begin_xfer(input int c, input int s, input int h);
    cmd = 2'(c); sec_in = 8'(s); head_in = 5'(h); start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic requests(input int n);
    req = 1'b1;
    for (int i = 0; i < n; i++) step();
    req = 1'b0;
    step();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "err", int'(err_o), 0);
    chk("R1", "sector", int'(sec_o), 0);
    chk("R1", "head", int'(head_o), 0);
    chk("R1", "first", int'(first_o), 0);
    rst_n = 1'b1;
    step();

    // R2 R8 R9: read run across the sector wrap, upper sector bits dropped
    cyl = 12'd5;
    begin_xfer(0, 8'hFE, 0);
    chk("R2", "loaded sector", int'(sec_o), 62);
    requests(4);
    chk("R9", "head after carry", int'(head_o), 1);

    // R4 no drive, even with write protect on a write
    present = 1'b0; wprot = 1'b1;
    begin_xfer(1, 3, 2);
    requests(1);
    present = 1'b1;
    // R5 write to protected drive, then a read on the same drive passes
    requests(1);
    begin_xfer(0, 3, 2);
    requests(1);
    wprot = 1'b0;

    // R6 bad cylinder, also with a bad head
    cyl = 12'd823;
    begin_xfer(0, 10, 7);
    requests(2);
    cyl = 12'd822;
    // R7 bad head on first sector
    requests(1);
    chk("R7", "first kept", int'(first_o), 1);

    // R7 bad head reached after passing sectors: cylinder overflow
    begin_xfer(0, 62, 4);
    requests(3);

    // R11 format adds write-protect flag and still advances
    cyl = 12'd100;
    begin_xfer(3, 5, 1);
    requests(2);
    // R11 read-check acts as read even with protect on
    wprot = 1'b1;
    begin_xfer(2, 20, 0);
    requests(2);
    wprot = 1'b0;

    // R2 request together with start is dropped
    cmd = 2'd0; sec_in = 8'd40; head_in = 5'd3; start = 1'b1; req = 1'b1;
    step();
    start = 1'b0; req = 1'b0;
    step();

    // R8 other geometry
    surf = 5'd19; cyl = 12'd700;
    begin_xfer(1, 63, 18);
    requests(2);
    surf = 5'd16; cyls = 12'd1024; cyl = 12'd1023;
    begin_xfer(0, 63, 15);
    requests(2);

    // R12 fill stage
    for (int k = 0; k < 8; k++) begin
      pad_wr   = k[0];
      pad_cnt  = (k < 2) ? 9'd0 : ((k < 4) ? 9'd256 : 9'd100);
      pad_idx  = (k < 6) ? 8'd99 : 8'd255;
      pad_data = 8'(8'h30 + k);
      pad_last = 8'hA5;
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule